// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the instruction address of a small processor core and computes its next value once per instruction cycle. When the step strobe is high, a decoded operation code picks the next address: count up by one, jump or call to a target inside the current 2K page, return to a saved address, load the low byte from a data value, or go to the interrupt entry point. When the strobe is low, the address holds.

The instruction field of a jump or call covers only the low eleven address bits. The two page bits above it come from an external five-bit high-address latch register. A write to the low byte uses all five latch bits as the upper address bits. The latch register belongs to the surrounding core. This block only reads it and never changes it.

Calls and interrupt entries save a full return address in a built-in circular stack. Returns take the most recent entry back off the stack. The stack pointer is hidden from the rest of the core, and the stack raises no flag for overflow or underflow: it wraps silently. Only the low byte of the address is offered for reading as a separate output.

Top module: `prog_addr_unit`

## Requirements
- R1: A synchronous active-high reset sets the address to 0000h and the low-byte output to 00h. It also empties the stack by returning its pointer to slot 0. Stack contents are not cleared.
- R2: When the step strobe is low, the address holds whatever the operation code is.
- R3: Operation code 0 (next) adds one to the address, and 1FFFh wraps to 0000h.
- R4: Operation code 1 (jump) loads the address with latch bits 4:3 as address bits 12:11 and the 11-bit target as bits 10:0. Latch bits 2:0 have no effect.
- R5: Operation code 2 (call) loads the same address as a jump. It also pushes the address of the call plus one.
- R6: Operation code 3 (return) loads the address from the most recently pushed stack entry that has not yet been popped, in last-in first-out order.
- R7: Operation code 4 (low-byte write) loads latch bits 4:0 as address bits 12:8 and the data byte as bits 7:0. The low-byte output then shows that data byte.
- R8: Operation code 5 (interrupt) loads 0004h and pushes the current, not yet executed, address.
- R9: The stack has 8 entries. After nine pushes, nine pops return the 9th, 8th, ... 2nd pushed addresses and then the 9th again, because the ninth push overwrote the first.
- R10: A pop with no entry outstanding returns the entry under the wrapped pointer. After 8 pushes and 8 pops, one more pop returns the 8th pushed address.
- R11: Operation codes 6 and 7 leave both the address and the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | One instruction cycle; applies op_i |
| op_i | input | 3 | Operation code (see R3 to R11) |
| target_i | input | 11 | Jump/call target field |
| data_i | input | 8 | Value for a low-byte write |
| latch_i | input | 5 | High-address latch register contents |
| addr_o | output | 13 | Current instruction address (registered) |
| low_o | output | 8 | Readable low byte of the address |

## Verification
The hardest conditions to reach are the stack wrap and a pop with nothing outstanding. The ports show neither the pointer nor any overflow flag, so both appear only as the address a return lands on. The stimulus reaches them with call chains that never return. It makes nine nested calls and unwinds all nine. Then it resets and makes eight calls followed by nine returns. Every call target is distinct, so each return address tells which slot was read. A full 8192-step count checks the 1FFFh wrap. Sweeps over all 32 latch values separate the page bits from the ignored latch bits.

// File: rtl/prog_addr_pkg.sv
package prog_addr_pkg;

  typedef enum logic [2:0] {
    OP_NEXT = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_WRLO = 3'd4,
    OP_VECT = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } pc_op_e;

endpackage

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int WIDTH = 13,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_en,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_en,
  output logic [WIDTH-1:0] top_data
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_inc;
  logic [PTR_W-1:0] ptr_dec;

  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign ptr_inc = ptr_q + PTR_W'(1);
      assign ptr_dec = ptr_q - PTR_W'(1);
    end else begin : g_mod
      assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
      assign ptr_dec = (ptr_q == '0) ? LAST : ptr_q - PTR_W'(1);
    end
  endgenerate

  // storage is never reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push_en) mem[ptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (push_en) ptr_q <= ptr_inc;
    else if (pop_en)  ptr_q <= ptr_dec;
  end

  assign top_data = mem[ptr_dec];

endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import prog_addr_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int LOW_W   = 8,
  parameter int TGT_W   = 11,
  parameter int IRQ_VEC = 4
) (
  input  logic [ADDR_W-1:0]       cur_addr,
  input  logic                    step,
  input  logic [2:0]              op,
  input  logic [TGT_W-1:0]        target,
  input  logic [LOW_W-1:0]        data,
  input  logic [ADDR_W-LOW_W-1:0] latch,
  input  logic [ADDR_W-1:0]       stack_top,
  output logic [ADDR_W-1:0]       nxt_addr,
  output logic                    push_en,
  output logic [ADDR_W-1:0]       push_data,
  output logic                    pop_en
);

  localparam int HI_W   = ADDR_W - LOW_W;
  localparam int PAGE_W = ADDR_W - TGT_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] VEC = ADDR_W'(IRQ_VEC);

  pc_op_e           op_e;
  logic [ADDR_W-1:0] incr;
  logic [ADDR_W-1:0] paged;

  assign op_e  = pc_op_e'(op);
  assign incr  = cur_addr + ONE;
  assign paged = {latch[HI_W-1 -: PAGE_W], target};

  always_comb begin
    nxt_addr  = cur_addr;
    push_en   = 1'b0;
    pop_en    = 1'b0;
    push_data = incr;
    if (step) begin
      case (op_e)
        OP_NEXT: nxt_addr = incr;
        OP_JUMP: nxt_addr = paged;
        OP_CALL: begin
          nxt_addr = paged;
          push_en  = 1'b1;
        end
        OP_RET: begin
          nxt_addr = stack_top;
          pop_en   = 1'b1;
        end
        OP_WRLO: nxt_addr = {latch, data};
        OP_VECT: begin
          nxt_addr  = VEC;
          push_en   = 1'b1;
          push_data = cur_addr;
        end
        default: nxt_addr = cur_addr;
      endcase
    end
  end

endmodule

// File: rtl/prog_addr_unit.sv
module prog_addr_unit #(
  parameter int ADDR_W  = 13,
  parameter int LOW_W   = 8,
  parameter int TGT_W   = 11,
  parameter int DEPTH   = 8,
  parameter int RST_VEC = 0,
  parameter int IRQ_VEC = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step_i,
  input  logic [2:0]              op_i,
  input  logic [TGT_W-1:0]        target_i,
  input  logic [LOW_W-1:0]        data_i,
  input  logic [ADDR_W-LOW_W-1:0] latch_i,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [LOW_W-1:0]        low_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] push_data;
  logic [ADDR_W-1:0] stack_top;
  logic              push_en;
  logic              pop_en;

  pc_next_sel #(
    .ADDR_W (ADDR_W),
    .LOW_W  (LOW_W),
    .TGT_W  (TGT_W),
    .IRQ_VEC(IRQ_VEC)
  ) sel_i (
    .cur_addr (addr_q),
    .step     (step_i),
    .op       (op_i),
    .target   (target_i),
    .data     (data_i),
    .latch    (latch_i),
    .stack_top(stack_top),
    .nxt_addr (nxt_addr),
    .push_en  (push_en),
    .push_data(push_data),
    .pop_en   (pop_en)
  );

  ret_stack #(
    .WIDTH(ADDR_W),
    .DEPTH(DEPTH)
  ) stk_i (
    .clk      (clk),
    .rst      (rst),
    .push_en  (push_en & ~rst),
    .push_data(push_data),
    .pop_en   (pop_en),
    .top_data (stack_top)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= ADDR_W'(RST_VEC);
    else     addr_q <= nxt_addr;
  end

  assign addr_o = addr_q;
  assign low_o  = addr_q[LOW_W-1:0];

endmodule

// File: rtl/prog_addr_unit_chk.sv
module prog_addr_unit_chk #(
  parameter int ADDR_W  = 13,
  parameter int LOW_W   = 8,
  parameter int TGT_W   = 11,
  parameter int RST_VEC = 0,
  parameter int IRQ_VEC = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    step_i,
  input logic [2:0]              op_i,
  input logic [TGT_W-1:0]        target_i,
  input logic [LOW_W-1:0]        data_i,
  input logic [ADDR_W-LOW_W-1:0] latch_i,
  input logic [ADDR_W-1:0]       addr_o
);

  localparam int HI_W   = ADDR_W - LOW_W;
  localparam int PAGE_W = ADDR_W - TGT_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> addr_o == ADDR_W'(RST_VEC));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(addr_o));

  assert_incr_R3: assert property (@(posedge clk) disable iff (rst)
    (step_i && op_i == 3'd0) |=> addr_o == $past(addr_o) + ONE);

  assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
    (step_i && op_i == 3'd1) |=>
      addr_o == {$past(latch_i[HI_W-1 -: PAGE_W]), $past(target_i)});

  assert_call_then_ret_R6: assert property (@(posedge clk) disable iff (rst)
    (step_i && op_i == 3'd3 && !$past(rst) && $past(step_i && op_i == 3'd2))
      |=> addr_o == $past(addr_o, 2) + ONE);

  assert_wrlo_R7: assert property (@(posedge clk) disable iff (rst)
    (step_i && op_i == 3'd4) |=> addr_o == {$past(latch_i), $past(data_i)});

  assert_vect_R8: assert property (@(posedge clk) disable iff (rst)
    (step_i && op_i == 3'd5) |=> addr_o == ADDR_W'(IRQ_VEC));

  assert_reserved_R11: assert property (@(posedge clk) disable iff (rst)
    (step_i && op_i[2:1] == 2'b11) |=> $stable(addr_o));

endmodule

bind prog_addr_unit prog_addr_unit_chk #(
  .ADDR_W (ADDR_W),
  .LOW_W  (LOW_W),
  .TGT_W  (TGT_W),
  .RST_VEC(RST_VEC),
  .IRQ_VEC(IRQ_VEC)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .step_i  (step_i),
  .op_i    (op_i),
  .target_i(target_i),
  .data_i  (data_i),
  .latch_i (latch_i),
  .addr_o  (addr_o)
);

// File: tb/prog_addr_unit_tb_top.sv
`timescale 1ns/1ps
module prog_addr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [10:0] target_i = '0;
  logic [7:0]  data_i = '0;
  logic [4:0]  latch_i = '0;
  logic [12:0] addr_o;
  logic [7:0]  low_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [12:0] exp_addr = '0;
  logic [12:0] m_stk [8];
  int          m_ptr = 0;

  always #10 clk = ~clk;

  prog_addr_unit dut_i (
    .clk(clk), .rst(rst), .step_i(step_i), .op_i(op_i),
    .target_i(target_i), .data_i(data_i), .latch_i(latch_i),
    .addr_o(addr_o), .low_o(low_o)
  );

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; step_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    exp_addr = '0; m_ptr = 0;
    chk("R1 addr", addr_o, 13'h0000);
    chk("R1 low", {5'h0, low_o}, 13'h0000);
  endtask

  task automatic run(input logic [2:0] op, input logic [10:0] tg,
                     input logic [7:0] dt, input logic [4:0] lt, input string req);
    logic [12:0] e;
    step_i = 1'b1; op_i = op; target_i = tg; data_i = dt; latch_i = lt;
    e = exp_addr;
    case (op)
      3'd0: e = exp_addr + 13'd1;
      3'd1: e = {lt[4:3], tg};
      3'd2: begin m_stk[m_ptr] = exp_addr + 13'd1; m_ptr = (m_ptr + 1) % 8; e = {lt[4:3], tg}; end
      3'd3: begin m_ptr = (m_ptr + 7) % 8; e = m_stk[m_ptr]; end
      3'd4: e = {lt, dt};
      3'd5: begin m_stk[m_ptr] = exp_addr; m_ptr = (m_ptr + 1) % 8; e = 13'h0004; end
      default: e = exp_addr;
    endcase
    @(posedge clk); #1;
    step_i = 1'b0;
    exp_addr = e;
    chk(req, addr_o, e);
    if (op == 3'd4) chk("R7 low byte", {5'h0, low_o}, {5'h0, dt});
  endtask

  task automatic idle(input logic [2:0] op);
    step_i = 1'b0; op_i = op; latch_i = 5'h1F; target_i = 11'h555;
    @(posedge clk); #1;
    chk("R2 hold", addr_o, exp_addr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    // R3: full count through all 8192 addresses, ending wrapped at zero
    for (int i = 0; i < 8192; i++) run(3'd0, 11'h0, 8'h0, 5'h0, "R3 next");
    chk("R3 wrap", addr_o, 13'h0000);
    // R2: no strobe, every code
    for (int o = 0; o < 8; o++) idle(3'(o));
    // R4: all latch values, several targets
    for (int l = 0; l < 32; l++) begin
      run(3'd1, 11'h000, 8'h00, 5'(l), "R4 jump");
      run(3'd1, 11'h7FF, 8'h00, 5'(l), "R4 jump");
      run(3'd1, 11'(l * 61 + 3), 8'h00, 5'(l), "R4 jump");
    end
    // R7: all latch values, several data bytes
    for (int l = 0; l < 32; l++) begin
      run(3'd4, 11'h0, 8'h00, 5'(l), "R7 wrlo");
      run(3'd4, 11'h0, 8'hFF, 5'(l), "R7 wrlo");
      run(3'd4, 11'h0, 8'(l * 37 + 1), 5'(l), "R7 wrlo");
    end
    // R5/R6: nested calls then unwinding
    run(3'd1, 11'h100, 8'h0, 5'h08, "R4 jump");
    run(3'd2, 11'h234, 8'h0, 5'h18, "R5 call");
    run(3'd0, 11'h0, 8'h0, 5'h0, "R3 next");
    run(3'd2, 11'h7F0, 8'h0, 5'h07, "R5 call");
    run(3'd2, 11'h011, 8'h0, 5'h10, "R5 call");
    run(3'd3, 11'h0, 8'h0, 5'h0, "R6 ret");
    run(3'd3, 11'h0, 8'h0, 5'h0, "R6 ret");
    run(3'd3, 11'h0, 8'h0, 5'h0, "R6 ret");
    // R8: interrupt saves the unexecuted address
    run(3'd4, 11'h0, 8'h9A, 5'h13, "R7 wrlo");
    run(3'd5, 11'h0, 8'h0, 5'h1F, "R8 vect");
    run(3'd0, 11'h0, 8'h0, 5'h0, "R3 next");
    run(3'd3, 11'h0, 8'h0, 5'h0, "R8 ret to saved");
    // R11: reserved codes touch neither address nor stack
    run(3'd2, 11'h3C3, 8'h0, 5'h08, "R5 call");
    run(3'd6, 11'h7FF, 8'hFF, 5'h1F, "R11 code6");
    run(3'd7, 11'h7FF, 8'hFF, 5'h1F, "R11 code7");
    run(3'd3, 11'h0, 8'h0, 5'h0, "R11 stack intact");
    // R9: nine nested calls wrap the stack
    do_reset();
    for (int k = 0; k < 9; k++) run(3'd2, 11'(k * 100 + 7), 8'h0, 5'(k * 9), "R9 call");
    for (int k = 0; k < 9; k++) run(3'd3, 11'h0, 8'h0, 5'h0, "R9 ret");
    // R10: pop with nothing outstanding
    do_reset();
    for (int k = 0; k < 8; k++) run(3'd2, 11'(k * 211 + 1), 8'h0, 5'(k * 5), "R10 call");
    for (int k = 0; k < 9; k++) run(3'd3, 11'h0, 8'h0, 5'h0, "R10 ret");
    summary();
  end

endmodule